// File: doc/BRIEF.md
# Register-Write Command List Executor

This block walks a list of register-programming instructions held in memory and turns each one into a write on a register-write port. Software sets an enable bit, points the head pointer at the first instruction and then writes the tail pointer. The tail write starts the run. The engine fetches 32-bit words one at a time over a request/response memory port. It decodes each 8-byte instruction slot and stops when its fetch pointer reaches the tail.

Two instruction kinds are understood. A direct write carries one value, its byte enables and a register offset. An indexed write carries a count, a register offset and then that many data words, all sent to the same offset. It is followed by one padding word when that is needed to bring the next instruction back onto an 8-byte boundary. The engine never reads registers. A slot made of two zero words does nothing. An unknown opcode raises a sticky fault and halts the run.

Top module: `cmdlist_exec`

## Requirements
- R1: After reset, `run_en`, `busy`, `fault`, `mem_req` and `reg_wr` are all low.
- R2: Configuration writes use `cfg_sel` 0 for control, 1 for head and 2 for tail. In a control write, bit 0 sets the enable and a 1 in bit 1 clears the fault. A tail write made while enabled and idle raises `busy` on the next clock edge. A tail write made while disabled starts nothing.
- R3: A direct write slot has its data value in word 0. Word 1 holds opcode 0x01 in bits 31:24, byte enables in bits 23:20 and the register offset in bits 19:0. The slot produces exactly one `reg_wr` pulse with those fields.
- R4: An indexed write slot has a count N in word 0. Word 1 holds opcode 0x09 in bits 31:24 and the register offset in bits 19:0. The N words that follow are each written, in memory order, to that offset with byte enables 4'hF.
- R5: When the last data word of an indexed write sits at an even word index, the word after it is padding. The padding word is skipped whatever its value. An indexed write with N equal to 0 produces no writes.
- R6: A slot whose two words are both zero produces no register write.
- R7: The engine stops fetching when its word pointer equals the tail, and `busy` then falls. No fetch is made at or beyond the tail. When head equals tail, the run makes no fetch at all.
- R8: An opcode other than 0x01 or 0x09, in a slot that is not all zero, sets `fault`, clears `busy` and stops all further fetches and writes. `fault` stays set until a control write with bit 1 set.
- R9: Head and tail writes made while `busy` is high are ignored. The current run ends at its original tail, and a later run starts from the previously stored head.
- R10: At most one memory request is in flight. `mem_req` is never high on two consecutive cycles, and fetch addresses are word aligned byte addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 control, 1 head, 2 tail |
| cfg_wdata | input | AW | Configuration data (byte address or control bits) |
| run_en | output | 1 | Enable bit |
| busy | output | 1 | Run in progress |
| fault | output | 1 | Sticky unknown-opcode flag |
| mem_req | output | 1 | One-cycle word fetch request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| reg_wr | output | 1 | Register write pulse |
| reg_addr | output | OFFW | Register offset |
| reg_data | output | 32 | Register write data |
| reg_be | output | 4 | Byte enables |

## Verification
The hardest case to reach is a head or tail write that lands while a run is still in progress. That run is only a few dozen cycles long. The bench builds a long indexed list, starts it, and at once issues a head write and a tail write that both point elsewhere. It then checks that the write count and the fetch count still match the original list. A second run, started by a tail write alone, shows that the ignored head never took effect. Padding is checked by filling the pad word with a nonzero pattern, so any attempt to decode it would show up as an extra write or a fault.

// File: rtl/cmdlist_exec.sv
module cmdlist_exec #(
  parameter int AW   = 16,
  parameter int OFFW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  output logic            run_en,
  output logic            busy,
  output logic            fault,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_rvalid,
  input  logic [31:0]     mem_rdata,
  output logic            reg_wr,
  output logic [OFFW-1:0] reg_addr,
  output logic [31:0]     reg_data,
  output logic [3:0]      reg_be
);
  localparam int PW = AW - 2;
  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT} st_t;
  typedef enum logic [1:0] {P_W0, P_W1, P_DATA, P_PAD} ph_t;

  st_t            st;
  ph_t            ph;
  logic [PW-1:0]  ptr, head, tail;
  logic [31:0]    w0, cnt;
  logic [OFFW-1:0] off;

  wire wr_ctrl = cfg_we && cfg_sel == 2'd0;
  wire wr_head = cfg_we && cfg_sel == 2'd1;
  wire wr_tail = cfg_we && cfg_sel == 2'd2;
  wire start   = wr_tail && !busy && run_en;
  wire at_tail = ptr == tail;
  wire [7:0] opc = mem_rdata[31:24];
  wire zero_slot = w0 == 32'd0 && mem_rdata == 32'd0;

  assign mem_req  = st == S_FETCH && !at_tail;
  assign mem_addr = {ptr, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_W0;
      ptr <= '0; head <= '0; tail <= '0;
      w0 <= '0; cnt <= '0; off <= '0;
      run_en <= 1'b0; busy <= 1'b0; fault <= 1'b0;
      reg_wr <= 1'b0; reg_addr <= '0; reg_data <= '0; reg_be <= '0;
    end else begin
      reg_wr <= 1'b0;
      if (wr_ctrl) begin
        run_en <= cfg_wdata[0];
        if (cfg_wdata[1]) fault <= 1'b0;
      end
      if (wr_head && !busy) head <= cfg_wdata[AW-1:2];
      if (wr_tail && !busy) tail <= cfg_wdata[AW-1:2];
      if (start) begin
        busy <= 1'b1;
        st   <= S_FETCH;
        ptr  <= head;
        ph   <= P_W0;
      end
      case (st)
        S_FETCH: begin
          if (at_tail) begin
            busy <= 1'b0;
            st   <= S_IDLE;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: if (mem_rvalid) begin
          ptr <= ptr + 1'b1;
          st  <= S_FETCH;
          case (ph)
            P_W0: begin
              w0 <= mem_rdata;
              ph <= P_W1;
            end
            P_W1: begin
              ph <= P_W0;
              if (zero_slot) begin
              end else if (opc == OP_DIRECT) begin
                reg_wr   <= 1'b1;
                reg_addr <= mem_rdata[OFFW-1:0];
                reg_be   <= mem_rdata[23:20];
                reg_data <= w0;
              end else if (opc == OP_INDEXED) begin
                cnt <= w0;
                off <= mem_rdata[OFFW-1:0];
                if (w0 != 32'd0) ph <= P_DATA;
              end else begin
                fault <= 1'b1;
                busy  <= 1'b0;
                st    <= S_IDLE;
              end
            end
            P_DATA: begin
              reg_wr   <= 1'b1;
              reg_addr <= off;
              reg_be   <= 4'hF;
              reg_data <= mem_rdata;
              cnt      <= cnt - 1'b1;
              if (cnt == 32'd1) ph <= ptr[0] ? P_W0 : P_PAD;
            end
            default: ph <= P_W0;
          endcase
        end
        default: ;
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !busy && !reg_wr);

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_tail && run_en));

  assert_write_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> busy);

  assert_idle_no_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !(wr_ctrl && cfg_wdata[1]) |=> fault);

  assert_fault_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> !busy);

  assert_ptrs_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tail) && $stable(head));

  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
endmodule

// File: tb/sim_cmdlist_exec.sv
module sim_cmdlist_exec;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic run_en, busy, fault, mem_req, reg_wr;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [19:0] reg_addr;
  logic [31:0] reg_data;
  logic [3:0] reg_be;

  always #10 clk = ~clk;

  cmdlist_exec #(.AW(AW), .OFFW(20)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .run_en(run_en), .busy(busy), .fault(fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data), .reg_be(reg_be));

  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem[mem_addr[11:2]];
  end

  logic [19:0] log_a [0:63];
  logic [31:0] log_d [0:63];
  logic [3:0]  log_b [0:63];
  int nlog = 0;
  int nfetch = 0;
  int nchk = 0;
  int nerr = 0;

  always @(negedge clk) begin
    if (reg_wr) begin
      if (nlog < 64) begin
        log_a[nlog] = reg_addr; log_d[nlog] = reg_data; log_b[nlog] = reg_be;
      end
      nlog = nlog + 1;
    end
    if (mem_req) nfetch = nfetch + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_wr(input int i, input logic [19:0] a, input logic [31:0] d, input logic [3:0] b, input string req);
    check(log_a[i] == a, req, {12'd0, log_a[i]}, {12'd0, a});
    check(log_d[i] == d, req, log_d[i], d);
    check(log_b[i] == b, req, {28'd0, log_b[i]}, {28'd0, b});
  endtask

  task automatic run_list(input logic [AW-1:0] hd, input logic [AW-1:0] tl);
    nlog = 0; nfetch = 0;
    cfg(2'd1, hd);
    cfg(2'd2, tl);
    check(busy === 1'b1, "R2 busy after tail write", {31'd0, busy}, 32'd1);
    wait_idle();
    check(busy === 1'b0, "R7 busy falls at tail", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    check(run_en === 1'b0 && busy === 1'b0 && fault === 1'b0, "R1 status after reset",
          {29'd0, run_en, busy, fault}, 32'd0);
    check(mem_req === 1'b0 && reg_wr === 1'b0, "R1 ports quiet after reset",
          {30'd0, mem_req, reg_wr}, 32'd0);
  endtask

  task automatic t_disabled();
    nlog = 0; nfetch = 0;
    cfg(2'd1, 12'h000);
    cfg(2'd2, 12'h040);
    repeat (6) @(negedge clk);
    check(busy === 1'b0, "R2 no start while disabled", {31'd0, busy}, 32'd0);
    check(nfetch == 0 && nlog == 0, "R2 no traffic while disabled", nfetch + nlog, 32'd0);
    cfg(2'd0, 12'h001);
    check(run_en === 1'b1, "R2 enable bit set", {31'd0, run_en}, 32'd1);
  endtask

  task automatic t_direct();
    mem[0] = 32'hDEADBEEF; mem[1] = 32'h01501234;
    mem[2] = 32'h11111111; mem[3] = 32'h01F00ABC;
    run_list(12'h000, 12'h040);
    check(nlog == 2, "R3 R6 direct write count", nlog, 2);
    expect_wr(0, 20'h01234, 32'hDEADBEEF, 4'h5, "R3 first direct write");
    expect_wr(1, 20'h00ABC, 32'h11111111, 4'hF, "R3 second direct write");
    check(nfetch == 16, "R7 fetches stop at tail", nfetch, 16);
  endtask

  task automatic t_indexed();
    mem[64] = 3; mem[65] = 32'h09002000;
    mem[66] = 32'hA0000001; mem[67] = 32'hA0000002; mem[68] = 32'hA0000003;
    mem[69] = 32'hBAD0BAD0;
    mem[70] = 2; mem[71] = 32'h09003000;
    mem[72] = 32'hB0000001; mem[73] = 32'hB0000002;
    mem[74] = 32'h5555AAAA; mem[75] = 32'h01C00044;
    run_list(12'h100, 12'h140);
    check(nlog == 6, "R4 R5 indexed write count", nlog, 6);
    expect_wr(0, 20'h02000, 32'hA0000001, 4'hF, "R4 indexed data 1");
    expect_wr(2, 20'h02000, 32'hA0000003, 4'hF, "R4 indexed data 3");
    expect_wr(3, 20'h03000, 32'hB0000001, 4'hF, "R5 slot after pad decoded");
    expect_wr(4, 20'h03000, 32'hB0000002, 4'hF, "R4 even-length indexed");
    expect_wr(5, 20'h00044, 32'h5555AAAA, 4'hC, "R5 no pad after odd end");
    check(fault === 1'b0, "R5 pad word not decoded", {31'd0, fault}, 32'd0);
  endtask

  task automatic t_zero_len();
    mem[128] = 0; mem[129] = 32'h09000100;
    mem[130] = 0; mem[131] = 0;
    mem[132] = 32'h12345678; mem[133] = 32'h01300FFF;
    run_list(12'h200, 12'h240);
    check(nlog == 1, "R5 R6 zero count and no-op slot", nlog, 1);
    expect_wr(0, 20'h00FFF, 32'h12345678, 4'h3, "R6 write after no-op");
  endtask

  task automatic t_empty();
    run_list(12'h040, 12'h040);
    check(nfetch == 0 && nlog == 0, "R7 empty run fetches nothing", nfetch + nlog, 0);
  endtask

  task automatic t_error();
    mem[192] = 1; mem[193] = 32'h07000010;
    mem[194] = 32'h0000CAFE; mem[195] = 32'h01F00020;
    run_list(12'h300, 12'h340);
    check(fault === 1'b1, "R8 fault on unknown opcode", {31'd0, fault}, 32'd1);
    check(nlog == 0, "R8 no writes after fault", nlog, 0);
    check(nfetch == 2, "R8 fetch halts at fault", nfetch, 2);
    repeat (4) @(negedge clk);
    check(fault === 1'b1, "R8 fault sticky", {31'd0, fault}, 32'd1);
    cfg(2'd0, 12'h003);
    check(fault === 1'b0 && run_en === 1'b1, "R8 fault cleared by control", {30'd0, fault, run_en}, 32'd1);
  endtask

  task automatic t_busy_ignore();
    mem[256] = 8; mem[257] = 32'h09000500;
    for (int i = 0; i < 8; i++) mem[258 + i] = 32'h000000D0 + i;
    nlog = 0; nfetch = 0;
    cfg(2'd1, 12'h400);
    cfg(2'd2, 12'h440);
    cfg(2'd1, 12'h000);
    cfg(2'd2, 12'h800);
    check(busy === 1'b1, "R9 still busy during ignored writes", {31'd0, busy}, 32'd1);
    wait_idle();
    check(nlog == 8, "R9 run ends at original tail", nlog, 8);
    check(nfetch == 16, "R9 fetch count unchanged", nfetch, 16);
    expect_wr(7, 20'h00500, 32'h000000D7, 4'hF, "R4 last of eight");
    nlog = 0; nfetch = 0;
    cfg(2'd2, 12'h440);
    wait_idle();
    check(nlog == 8 && nfetch == 16, "R9 head write during run ignored", nlog, 8);
  endtask

  int mreq_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mreq_prev == 1) check(1'b0, "R10 back-to-back request", 32'd1, 32'd0);
      if (mem_req && mem_addr[1:0] != 2'b00) check(1'b0, "R10 unaligned fetch", {30'd0, mem_addr[1:0]}, 32'd0);
      mreq_prev = mem_req ? 1 : 0;
    end
  end

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_direct();
    t_indexed();
    t_zero_len();
    t_empty();
    t_error();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule